// File: doc/BRIEF.md
# Single-Slope Conversion Timer Capture

This block does the digital timing for a set of single-slope analog-to-digital conversions. Outside the block, an analog ramp starts again at every PWM synchronisation pulse. Four comparators, three main and one auxiliary, each go high when the ramp passes the voltage on their own channel. Inside the block, one conversion timer is shared by all four channels. It is held at zero while a window-start pulse is high. When the pulse drops, the timer counts up, at the full system clock rate or at half of it, and stops at a 12-bit ceiling. The first rising edge seen on a comparator during a window latches the timer value as that channel's conversion result.

At the start of the next window, all four results are published together. A channel whose comparator tripped gets its latched value and a valid flag. A channel whose comparator never tripped gets zero with the flag clear. In double-update operation a mid-period pulse from the PWM generator also opens a new window, so each window lasts half a PWM period. In single-update operation that pulse is ignored and each window lasts the full period. A plain select input picks which channel's published result and valid flag appear on the read port.

Top module: `slope_adc_capture`

## Requirements
- R1: When `full_rate` is 1, the timer advances on every clock after the window-start pulse drops. Take a comparator that rises after the m-th clock edge with the pulse low (m = 0 means it rises together with the pulse falling). Its result is m+2, which accounts for two synchroniser stages and one edge-detect stage.
- R2: When `full_rate` is 0, the timer advances on every second clock, so the same comparator timing gives floor((m+2)/2).
- R3: The timer stops at 4095 and never wraps. A trip after the ceiling is reached reads 4095.
- R4: Within a window, only the first rising edge of each comparator latches a value. Falls and later rises are ignored until the next window starts.
- R5: A comparator edge that occurs while the window-start pulse is high is ignored. A comparator that rose during the pulse and stays high reads zero.
- R6: A channel with no accepted rising edge in the window reads 0x000 with its valid flag clear. This includes an edge that comes too late to reach the timer before the window closes (m+3 greater than the number of low-pulse edges in the window).
- R7: All results and valid flags update together on the first clock edge of each window-start pulse and hold steady until the next one. A tripped channel reads valid = 1.
- R8: When `double_update` is 1, `mid_pulse` opens a window just as `sync_pulse` does. When `double_update` is 0, `mid_pulse` has no effect on the timer or on the results.
- R9: After reset, every channel reads 0x000 with its valid flag clear.
- R10: `rd_sel` value 0, 1 or 2 selects a main channel and value 3 selects the auxiliary channel. The read port is combinational from the published registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_pulse | input | 1 | PWM synchronisation pulse; high holds the timer at zero, rising edge opens a window |
| mid_pulse | input | 1 | Mid-period pulse, used only in double-update operation |
| double_update | input | 1 | 1 selects double-update (half-period windows) |
| full_rate | input | 1 | Mode-control bit: 1 counts every clock, 0 every second clock |
| cmp_in | input | 4 | Asynchronous comparator outputs; bit 3 is the auxiliary channel |
| rd_sel | input | 2 | Channel select for the read port |
| rd_data | output | 12 | Published result of the selected channel |
| rd_valid | output | 1 | Valid flag of the selected channel |

## Verification
The published results are the only visible state, so an error in the timer, the capture flags or the prescaler shows up at the read port on the first clock edge of the next window-start pulse, and no sooner. A wrong timer rate or a wrong synchroniser depth shifts every result by a predictable amount, which the bench checks exactly against a given comparator timing. A capture flag that clears or stays set when it should not produces either a later value or a zero. Both can be seen one window later. A timer that wraps past the ceiling turns a near-4095 result into a small one.

// File: rtl/slope_adc_pkg.sv
// Shared sizing for the single-slope conversion timer capture.
package slope_adc_pkg;
    localparam int CNT_W  = 12; // timer and result width
    localparam int NUM_CH = 4;  // three main channels plus one auxiliary
    localparam int SYNC_N = 2;  // synchroniser depth ahead of the edge detect
endpackage

// File: rtl/conv_timer.sv
// Shared conversion timer.
// Does: clears and holds at zero while hold is high, then counts up every
// clock (full_rate=1) or every second clock (full_rate=0), stopping at all-ones.
// Assumes: hold and full_rate are synchronous to clk.
module conv_timer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic         full_rate,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] CEIL = '1;

    logic phase;
    logic adv;

    // Prescale phase: restarts with each hold, toggles otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)    phase <= 1'b0;
        else if (hold) phase <= 1'b0;
        else           phase <= ~phase;
    end

    assign adv = full_rate | phase;

    // Timer register: cleared by hold, saturating increment otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                       count <= '0;
        else if (hold)                    count <= '0;
        else if (adv && (count != CEIL))  count <= count + 1'b1;
    end

    a_r1_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (count == '0));

    a_r3_ceiling_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && count == CEIL) |=> (hold || count == CEIL));

    a_r2_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !full_rate && $past(!hold) && $past(!full_rate)
         && count == $past(count) + 1'b1)
        |=> (full_rate || hold || $stable(count)));
endmodule

// File: rtl/cmp_sync_edge.sv
// Comparator input conditioning.
// Does: passes an asynchronous comparator level through an N-flop
// synchroniser, then flags a one-cycle rising edge.
// Assumes: N >= 2.
module cmp_sync_edge #(
    parameter int N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic rise
);
    logic [N-1:0] chain;
    logic         prev;

    // Synchroniser chain: raw enters at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[N-2:0], raw};
    end

    // Delayed copy of the synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[N-1];
    end

    assign rise = chain[N-1] & ~prev;
endmodule

// File: rtl/chan_capture.sv
// Per-channel capture and publish.
// Does: latches the timer on the first accepted rise in a window; at each
// window boundary publishes the latched value (or zero) with a valid flag.
// Assumes: boundary is high for one cycle and only while hold is high.
module chan_capture #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rise,
    input  logic         hold,
    input  logic         boundary,
    input  logic [W-1:0] count,
    output logic [W-1:0] result,
    output logic         valid
);
    logic         got;
    logic [W-1:0] cap;

    // Capture stage: first rise outside hold wins; boundary re-arms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            got <= 1'b0;
            cap <= '0;
        end else if (boundary) begin
            got <= 1'b0;
        end else if (rise && !hold && !got) begin
            got <= 1'b1;
            cap <= count;
        end
    end

    // Publish stage: result registers change only at a boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            valid  <= 1'b0;
        end else if (boundary) begin
            result <= got ? cap : '0;
            valid  <= got;
        end
    end

    a_r4_first_only: assert property (@(posedge clk) disable iff (!rst_n)
        (got && !boundary) |=> (got && $stable(cap)));

    a_r5_hold_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !got) |=> !got);

    a_r6_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && !got) |=> (result == '0 && !valid));

    a_r7_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> ($stable(result) && $stable(valid)));
endmodule

// File: rtl/slope_adc_capture.sv
// Top: single-slope conversion timer capture.
// Does: forms the window hold and boundary from the sync and mid pulses,
// runs one shared timer and one capture slice per channel, and muxes the
// published results onto the read port.
// Assumes: sync_pulse, mid_pulse, mode inputs synchronous to clk;
// cmp_in asynchronous; NUM_CH is a power of two.
module slope_adc_capture
    import slope_adc_pkg::*;
#(
    parameter int W     = CNT_W,
    parameter int NCH   = NUM_CH,
    parameter int SYNCS = SYNC_N,
    localparam int SEL_W = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_pulse,
    input  logic             mid_pulse,
    input  logic             double_update,
    input  logic             full_rate,
    input  logic [NCH-1:0]   cmp_in,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [W-1:0]     rd_data,
    output logic             rd_valid
);
    logic           win_pulse;
    logic           win_d;
    logic           boundary;
    logic [W-1:0]   count;
    logic [W-1:0]   res [NCH];
    logic [NCH-1:0] vld;

    // Mid pulse counts only in double-update operation.
    assign win_pulse = sync_pulse | (double_update & mid_pulse);

    // Delayed window pulse for rising-edge boundary detection.
    always_ff @(posedge clk) begin
        if (!rst_n) win_d <= 1'b0;
        else        win_d <= win_pulse;
    end

    assign boundary = win_pulse & ~win_d;

    conv_timer #(.W(W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (win_pulse),
        .full_rate (full_rate),
        .count     (count)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic rise;

        cmp_sync_edge #(.N(SYNCS)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (cmp_in[c]),
            .rise  (rise)
        );

        chan_capture #(.W(W)) u_cap (
            .clk      (clk),
            .rst_n    (rst_n),
            .rise     (rise),
            .hold     (win_pulse),
            .boundary (boundary),
            .count    (count),
            .result   (res[c]),
            .valid    (vld[c])
        );
    end

    // Read mux (R10): select picks one channel's published pair.
    assign rd_data  = res[rd_sel];
    assign rd_valid = vld[rd_sel];

    a_r8_single_ignores_mid: assert property (@(posedge clk) disable iff (!rst_n)
        (!double_update && !sync_pulse) |=> !win_d);
endmodule

// File: tb/slope_adc_capture_tb_top.sv
`timescale 1ns/1ps
module slope_adc_capture_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_pulse = 1'b1;
    logic        mid_pulse = 1'b0;
    logic        double_update = 1'b0;
    logic        full_rate = 1'b1;
    logic [3:0]  cmp_in = '0;
    logic [1:0]  rd_sel = '0;
    logic [11:0] rd_data;
    logic        rd_valid;

    int n_checks = 0;
    int n_fail   = 0;
    int ra [4];
    int fa [4];
    int rb [4];

    always #2.5 clk = ~clk;

    slope_adc_capture dut_i (
        .clk(clk), .rst_n(rst_n), .sync_pulse(sync_pulse), .mid_pulse(mid_pulse),
        .double_update(double_update), .full_rate(full_rate), .cmp_in(cmp_in),
        .rd_sel(rd_sel), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic check(input string tag, input int ch, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s ch%0d actual=%0d expected=%0d", tag, ch, act, exp);
        end
    endtask

    // Expected result from the requirements (R1, R2, R3, R6); -1 means no capture.
    function automatic int exp_val(input bit full, input int rise_at, input int len);
        int v;
        if (rise_at < 0 || rise_at + 3 > len) return -1;
        v = full ? rise_at + 2 : (rise_at + 2) / 2;
        return (v > 4095) ? 4095 : v;
    endfunction

    task automatic clear_events();
        for (int c = 0; c < 4; c++) begin ra[c] = -1; fa[c] = -1; rb[c] = -1; end
    endtask

    // Entry: at a negedge, one edge into a window-start pulse.
    // Exit: same position for the following window.
    task automatic run_window(input bit full, input bit via_mid, input int len,
                              input int mn, input logic [3:0] hmask, input string tag);
        int  e;
        bit  fl;
        cmp_in = hmask;               // R5: rises during hold
        repeat (4) @(negedge clk);
        sync_pulse = 1'b0; mid_pulse = 1'b0;
        double_update = via_mid; full_rate = full;
        for (int k = 0; k < len; k++) begin
            for (int c = 0; c < 4; c++) begin
                if (k == ra[c]) cmp_in[c] = 1'b1;
                if (k == fa[c]) cmp_in[c] = 1'b0;  // R4: toggles ignored
                if (k == rb[c]) cmp_in[c] = 1'b1;
            end
            if (mn >= 0 && k == mn)     mid_pulse = 1'b1; // R8: ignored in single
            if (mn >= 0 && k == mn + 2) mid_pulse = 1'b0;
            @(negedge clk);
        end
        cmp_in = '0;
        if (via_mid) mid_pulse = 1'b1; else sync_pulse = 1'b1;
        @(negedge clk);
        fl = full;
        for (int c = 0; c < 4; c++) begin
            rd_sel = 2'(c);           // R10 select encoding
            #0.5;
            e = exp_val(fl, ra[c], len);
            if (e < 0) begin
                check({tag, " R6 data"}, c, int'(rd_data), 0);
                check({tag, " R6 valid"}, c, int'(rd_valid), 0);
            end else begin
                check({tag, (e == 4095) ? " R3" : (fl ? " R1" : " R2"), " data"},
                      c, int'(rd_data), e);
                check({tag, " R7 valid"}, c, int'(rd_valid), 1);
            end
        end
        clear_events();
    endtask

    initial begin : watchdog
        #(5.0 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        int len;
        clear_events();
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        for (int c = 0; c < 4; c++) begin
            rd_sel = 2'(c);
            #0.5;
            check("R9 reset data", c, int'(rd_data), 0);
            check("R9 reset valid", c, int'(rd_valid), 0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Full rate, R1 with m=0 edge case, R6 never trips.
        ra[0] = 5; ra[1] = 0; ra[2] = 20;
        run_window(1'b1, 1'b0, 60, -1, 4'b0000, "dir1");
        // Half rate, R2, last capturable edge on channel 3.
        ra[0] = 5; ra[1] = 10; ra[2] = 33; ra[3] = 57;
        run_window(1'b0, 1'b0, 60, -1, 4'b0000, "dir2");
        // R4 toggles, R5 rise during hold on ch2, R6 edge too late on ch3.
        ra[0] = 4; fa[0] = 10; rb[0] = 20;
        ra[1] = 4; fa[1] = 5;  rb[1] = 6;
        ra[3] = 58;
        run_window(1'b1, 1'b0, 60, -1, 4'b0100, "dir3 R4 R5");
        // R3 ceiling at full rate.
        ra[0] = 4100; ra[1] = 4092; ra[2] = 4093;
        run_window(1'b1, 1'b0, 4200, -1, 4'b0000, "dir4");
        // R3 ceiling at half rate.
        ra[0] = 8200; ra[1] = 8186;
        run_window(1'b0, 1'b0, 8300, -1, 4'b0000, "dir5");
        // R8: mid pulse ignored in single-update operation.
        ra[0] = 30; ra[1] = 10;
        run_window(1'b1, 1'b0, 50, 15, 4'b0000, "dir6 R8 single");
        // R8: mid pulse closes windows in double-update operation.
        ra[0] = 12; ra[3] = 2;
        run_window(1'b1, 1'b1, 40, -1, 4'b0000, "dir7 R8 double");
        ra[1] = 7;
        run_window(1'b0, 1'b1, 30, -1, 4'b0000, "dir8 R8 double");

        for (int w = 0; w < 40; w++) begin
            bit         f, vm;
            int         mn;
            logic [3:0] hm;
            len = 10 + int'($urandom_range(390, 0));
            f   = 1'($urandom_range(1, 0));
            vm  = 1'($urandom_range(1, 0));
            hm  = '0;
            for (int c = 0; c < 4; c++) begin
                if ($urandom_range(4, 0) == 0) begin
                    if ($urandom_range(1, 0) == 1) hm[c] = 1'b1;
                end else begin
                    ra[c] = int'($urandom_range(len + 2, 0));
                    if ($urandom_range(1, 0) == 1) begin
                        fa[c] = ra[c] + 1 + int'($urandom_range(5, 0));
                        rb[c] = fa[c] + 1 + int'($urandom_range(5, 0));
                    end
                end
            end
            mn = (!vm && len > 20 && $urandom_range(1, 0) == 1)
                 ? int'($urandom_range(len - 3, 0)) : -1;
            run_window(f, vm, len, mn, hm, "rand");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule